// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit fixed-format instruction into the control lines that steer a simple datapath. The covered subset is register add, subtract, and, or, set-less-than, word load, word store, branch-if-equal and add-immediate. Decoding works in two levels. A main decoder looks at the opcode alone. When the opcode is all zeros, it passes the choice of ALU operation to a second decoder, which reads the function field. Any other known opcode fixes both the controls and the ALU mode by itself.

The controls are held in a register, so they appear one clock after the fields are presented. The encodings that are not recognised, whether an unknown opcode or an unknown function code under the all-zero opcode, give an all-zero control word. That word enables neither a register write nor a memory write. A synchronous active-high reset clears the control register.

Top module: `insn_ctl_decoder`

## Requirements
- R1: On a clock edge with `rst` high, every control output goes to 0 and stays 0 until a clock edge with `rst` low.
- R2: With `rst` low, the control outputs reflect the `opcode`/`funct` values that were present at the previous rising clock edge (one cycle of latency).
- R3: Opcode 0x00 with a recognised function code gives reg_we=1, dst_rd=1, alu_src_imm=0, mem_we=0, mem_to_reg=0, branch=0.
- R4: Under opcode 0x00, alu_op is 010 for funct 0x20 (add), 110 for 0x22 (sub), 000 for 0x24 (and), 001 for 0x25 (or) and 111 for 0x2A (set-less-than).
- R5: Opcode 0x23 (load) gives reg_we=1, dst_rd=0, alu_src_imm=1, mem_we=0, mem_to_reg=1, branch=0, alu_op=010.
- R6: Opcode 0x2B (store) gives mem_we=1, alu_src_imm=1, alu_op=010, and all other controls 0.
- R7: Opcode 0x04 (branch-if-equal) gives branch=1, alu_op=110, and all other controls 0.
- R8: Opcode 0x08 (add-immediate) gives reg_we=1, alu_src_imm=1, alu_op=010, and all other controls 0.
- R9: For every nonzero opcode the function field has no effect on any output.
- R10: Any opcode other than 0x00, 0x23, 0x2B, 0x04 and 0x08 gives all control outputs 0, so no register or memory write is made.
- R11: Opcode 0x00 with a function code other than the five in R4 gives all control outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the control register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Primary operation field of the instruction |
| funct | input | 6 | Function field; it is used only when the opcode is 0x00 |
| reg_we | output | 1 | Register file write enable |
| dst_rd | output | 1 | 1 selects the rd field as destination, 0 selects rt |
| alu_src_imm | output | 1 | 1 feeds the sign-extended immediate to the ALU, 0 feeds the register |
| mem_we | output | 1 | Data memory write enable |
| mem_to_reg | output | 1 | 1 writes memory read data back, 0 writes the ALU result |
| branch | output | 1 | Marks a conditional equality branch |
| alu_op | output | 3 | ALU operation code |

## Verification
The only internal state in this block is the control register. A corrupted word therefore shows up at the ports exactly one clock after the fields that produced it, and it cannot persist beyond the next decode. A stuck or mis-wired bit in the main decoder shows up on every opcode that relies on that bit. A fault in the function-field decoder shows up only under opcode 0x00, and only as a wrong alu_op or a missed safe-zero. For this reason the stimulus sweeps all 64 opcodes and all 64 function codes, and it checks the unknown codes as closely as the known ones.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int ALUOP_W = 3;

  // opcode values
  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;

  // function values under OPC_RTYPE
  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  // ALU operation codes
  localparam logic [ALUOP_W-1:0] AOP_AND = 3'b000;
  localparam logic [ALUOP_W-1:0] AOP_OR  = 3'b001;
  localparam logic [ALUOP_W-1:0] AOP_ADD = 3'b010;
  localparam logic [ALUOP_W-1:0] AOP_SUB = 3'b110;
  localparam logic [ALUOP_W-1:0] AOP_SLT = 3'b111;

  typedef enum logic [1:0] {
    AM_NONE  = 2'd0,
    AM_ADD   = 2'd1,
    AM_SUB   = 2'd2,
    AM_FIELD = 2'd3
  } alu_mode_e;

  typedef struct packed {
    logic               reg_we;
    logic               dst_rd;
    logic               src_imm;
    logic               mem_we;
    logic               mem_to_reg;
    logic               branch;
    logic [ALUOP_W-1:0] alu_op;
  } ctl_t;
endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctl_t            base,
  output alu_mode_e       mode,
  output logic            is_rtype
);
  always_comb begin
    base     = '0;
    mode     = AM_NONE;
    is_rtype = 1'b0;
    unique case (opcode)
      OPC_RTYPE: begin
        is_rtype    = 1'b1;
        base.reg_we = 1'b1;
        base.dst_rd = 1'b1;
        mode        = AM_FIELD;
      end
      OPC_LOAD: begin
        base.reg_we     = 1'b1;
        base.src_imm    = 1'b1;
        base.mem_to_reg = 1'b1;
        mode            = AM_ADD;
      end
      OPC_STORE: begin
        base.src_imm = 1'b1;
        base.mem_we  = 1'b1;
        mode         = AM_ADD;
      end
      OPC_BEQ: begin
        base.branch = 1'b1;
        mode        = AM_SUB;
      end
      OPC_ADDI: begin
        base.reg_we  = 1'b1;
        base.src_imm = 1'b1;
        mode         = AM_ADD;
      end
      default: begin
        base = '0;
        mode = AM_NONE;
      end
    endcase
  end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
(
  input  alu_mode_e          mode,
  input  logic [FN_W-1:0]    funct,
  output logic [ALUOP_W-1:0] alu_op,
  output logic               fn_ok
);
  always_comb begin
    alu_op = AOP_AND;
    fn_ok  = 1'b1;
    unique case (mode)
      AM_ADD:  alu_op = AOP_ADD;
      AM_SUB:  alu_op = AOP_SUB;
      AM_FIELD: begin
        unique case (funct)
          FN_ADD:  alu_op = AOP_ADD;
          FN_SUB:  alu_op = AOP_SUB;
          FN_AND:  alu_op = AOP_AND;
          FN_OR:   alu_op = AOP_OR;
          FN_SLT:  alu_op = AOP_SLT;
          default: fn_ok  = 1'b0;
        endcase
      end
      default: alu_op = AOP_AND;
    endcase
  end
endmodule

// File: rtl/ctl_out_reg.sv
module ctl_out_reg
  import ctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t d,
  output ctl_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/insn_ctl_decoder.sv
module insn_ctl_decoder
  import ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  input  logic [FN_W-1:0]    funct,
  output logic               reg_we,
  output logic               dst_rd,
  output logic               alu_src_imm,
  output logic               mem_we,
  output logic               mem_to_reg,
  output logic               branch,
  output logic [ALUOP_W-1:0] alu_op
);
  ctl_t               base_c;
  alu_mode_e          mode_c;
  logic               rtype_c;
  logic [ALUOP_W-1:0] aop_c;
  logic               fn_ok_c;
  ctl_t               next_c;
  ctl_t               ctl_q;

  ctl_main_dec u_main (
    .opcode   (opcode),
    .base     (base_c),
    .mode     (mode_c),
    .is_rtype (rtype_c)
  );

  ctl_alu_dec u_alu (
    .mode   (mode_c),
    .funct  (funct),
    .alu_op (aop_c),
    .fn_ok  (fn_ok_c)
  );

  // merge both levels; an undefined function code collapses to the safe word
  always_comb begin
    next_c        = base_c;
    next_c.alu_op = aop_c;
    if (rtype_c && !fn_ok_c) next_c = '0;
  end

  ctl_out_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d   (next_c),
    .q   (ctl_q)
  );

  assign reg_we      = ctl_q.reg_we;
  assign dst_rd      = ctl_q.dst_rd;
  assign alu_src_imm = ctl_q.src_imm;
  assign mem_we      = ctl_q.mem_we;
  assign mem_to_reg  = ctl_q.mem_to_reg;
  assign branch      = ctl_q.branch;
  assign alu_op      = ctl_q.alu_op;
endmodule

// File: rtl/insn_ctl_decoder_chk.sv
module insn_ctl_decoder_chk
  import ctl_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [OP_W-1:0]    opcode,
  input logic [FN_W-1:0]    funct,
  input logic               reg_we,
  input logic               dst_rd,
  input logic               alu_src_imm,
  input logic               mem_we,
  input logic               mem_to_reg,
  input logic               branch,
  input logic [ALUOP_W-1:0] alu_op
);
  logic            was_rst = 1'b0;
  logic            live    = 1'b0;
  logic [OP_W-1:0] op_d    = '0;
  logic            known_d = 1'b1;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    live    <= !rst;
    op_d    <= opcode;
    known_d <= (opcode == OPC_RTYPE) || (opcode == OPC_LOAD) ||
               (opcode == OPC_STORE) || (opcode == OPC_BEQ) ||
               (opcode == OPC_ADDI);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> !reg_we && !mem_we && !branch && !mem_to_reg && alu_op == '0); // R1

  AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !reg_we && alu_src_imm && alu_op == AOP_ADD); // R6

  AST_BRANCH_SUBTRACTS: assert property (@(posedge clk) disable iff (rst)
    branch |-> alu_op == AOP_SUB && !reg_we && !mem_we); // R7

  AST_LOAD_CONTROLS: assert property (@(posedge clk) disable iff (rst)
    live && op_d == OPC_LOAD |-> reg_we && mem_to_reg && alu_src_imm && !dst_rd); // R5

  AST_UNKNOWN_OP_SAFE: assert property (@(posedge clk) disable iff (rst)
    live && !known_d |-> !reg_we && !mem_we && !branch); // R10

  AST_RD_USES_REGS: assert property (@(posedge clk) disable iff (rst)
    dst_rd |-> !alu_src_imm && reg_we && !mem_to_reg); // R3
endmodule

bind insn_ctl_decoder insn_ctl_decoder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .opcode      (opcode),
  .funct       (funct),
  .reg_we      (reg_we),
  .dst_rd      (dst_rd),
  .alu_src_imm (alu_src_imm),
  .mem_we      (mem_we),
  .mem_to_reg  (mem_to_reg),
  .branch      (branch),
  .alu_op      (alu_op)
);

// File: tb/test_insn_ctl_decoder.sv
`timescale 1ns/1ps
module test_insn_ctl_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h23;
  logic [5:0] funct  = 6'h00;
  logic reg_we, dst_rd, alu_src_imm, mem_we, mem_to_reg, branch;
  logic [2:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [8:0] exp_q = '0;
  string      tag_q = "R1";

  always #4 clk = ~clk;

  insn_ctl_decoder i_insn_ctl_decoder (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .reg_we(reg_we), .dst_rd(dst_rd), .alu_src_imm(alu_src_imm),
    .mem_we(mem_we), .mem_to_reg(mem_to_reg), .branch(branch), .alu_op(alu_op)
  );

  // reference: {reg_we, dst_rd, src_imm, mem_we, mem_to_reg, branch, alu_op}
  function automatic logic [8:0] model(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'h00: begin
        case (fn)
          6'h20: return {6'b110000, 3'b010};
          6'h22: return {6'b110000, 3'b110};
          6'h24: return {6'b110000, 3'b000};
          6'h25: return {6'b110000, 3'b001};
          6'h2A: return {6'b110000, 3'b111};
          default: return 9'b0;
        endcase
      end
      6'h23: return {6'b101010, 3'b010};
      6'h2B: return {6'b001100, 3'b010};
      6'h04: return {6'b000001, 3'b110};
      6'h08: return {6'b101000, 3'b010};
      default: return 9'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
    logic [8:0] m;
    m = model(op, fn);
    case (op)
      6'h00: return (m == 9'b0) ? "R11" : "R3/R4";
      6'h23: return "R5";
      6'h2B: return "R6";
      6'h04: return "R7";
      6'h08: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic compare();
    logic [8:0] got;
    got = {reg_we, dst_rd, alu_src_imm, mem_we, mem_to_reg, branch, alu_op};
    checks++;
    if (got !== exp_q) begin
      errors++;
      $display("FAIL %s R2 got %b exp %b", tag_q, got, exp_q);
    end
  endtask

  // compare the word due now, then present the next fields
  task automatic step(input logic [5:0] op, input logic [5:0] fn, input string tag);
    @(negedge clk);
    compare();
    opcode = op;
    funct  = fn;
    exp_q  = model(op, fn);
    tag_q  = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    exp_q = '0; tag_q = "R1";
    compare();                              // R1 reset state with load fields present
    rst = 1'b0;
    opcode = 6'h2B; funct = 6'h3F;
    exp_q = model(6'h2B, 6'h3F); tag_q = "R6";
    // R4 / R3 / R11: every function code under the all-zero opcode
    for (int f = 0; f < 64; f++) step(6'h00, 6'(f), req_of(6'h00, 6'(f)));
    // every opcode with several function codes; R9 for non-zero opcodes
    for (int o = 0; o < 64; o++) begin
      for (int k = 0; k < 4; k++) begin
        logic [5:0] fv;
        fv = (k == 0) ? 6'h20 : (k == 1) ? 6'h2A : (k == 2) ? 6'h00 : 6'h3F;
        step(6'(o), fv, (o == 0) ? req_of(6'(o), fv) : {req_of(6'(o), fv), "/R9"});
      end
    end
    // R2: back-to-back changes each land one cycle later
    step(6'h04, 6'h22, "R7");
    step(6'h08, 6'h22, "R8");
    step(6'h23, 6'h24, "R5");
    step(6'h00, 6'h22, "R4");
    // R1: reset in mid-stream clears the word
    @(negedge clk);
    compare();
    rst = 1'b1; opcode = 6'h08;
    exp_q = '0; tag_q = "R1";
    step(6'h08, 6'h00, "R1");
    exp_q = '0; tag_q = "R1";
    @(negedge clk);
    compare();
    rst = 1'b0;
    exp_q = model(opcode, funct); tag_q = "R8";
    step(6'h00, 6'h25, "R4");
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R2 got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule